// File: doc/BRIEF.md
# DCC Track Signal Encoder

This block generates the bipolar drive waveform for a model-railway DCC track from a free-running system clock. Every logical bit is a high half-period followed by a low half-period of the same length. A 1 uses the short half-period and a 0 uses the long one. With the default parameters at 80 MHz the halves are 58 µs and 100 µs. The block provides both the signal and its complement, so an H-bridge can be driven directly.

Once enabled, the encoder loops with no gaps. Each loop sends a preamble, then one packet body, then starts the next preamble. A host hands over packets of one to five bytes through a valid/ready port. The encoder adds the byte separators and the closing bit itself. If no host packet is waiting when the preamble finishes, the encoder sends a built-in filler body. On the main track this filler is the idle sequence. On the programming track it is a reset packet.

Top module: `dcc_track_encoder`

## Requirements
- R1: A 1 bit drives `track_p` high for ONE_HALF cycles and then low for ONE_HALF cycles (defaults to 4640 cycles).
- R2: A 0 bit drives `track_p` high for ZERO_HALF cycles and then low for ZERO_HALF cycles (defaults to 8000 cycles). Every bit ends in its low half.
- R3: While the encoder runs, `track_n` is the inverse of `track_p`. While it is stopped or in reset, both outputs are low.
- R4: Each preamble is N 1-bits followed by a single 0-bit. N is the value on `pre_len` in the cycle that preamble begins, and N = 0 gives a lone 0.
- R5: With no packet buffered and `prog_mode` low when the preamble ends, the body is 28 bits sent first to last: 1111 1111, 0000 0000 00, 1111 1111, 1, 0.
- R6: A host body sends byte k (from `pkt_data[8k+7:8k]`) as the k-th byte, most significant bit first. A 0 follows every byte except the last, and a 1 follows the last. The body is therefore 9 × count bits long.
- R7: `pkt_ready` is high exactly when the one-packet buffer is empty. A beat with `pkt_valid` and `pkt_ready` high and `pkt_count` in 1..5 fills the buffer. A beat with any other count is dropped and leaves the buffer empty.
- R8: A buffered packet is moved into transmission only when the preamble's final bit ends, and the buffer becomes free in that same cycle. The preamble, body and next preamble follow one another with no idle cycle between bits.
- R9: With no packet buffered and `prog_mode` high when the preamble ends, the body is two 0x00 bytes framed as in R6 (eighteen bits: eight 0, 0, eight 0, 1).
- R10: Synchronous `rst` clears the buffer and drives both outputs low. The first preamble bit goes high in the cycle after `enable` is sampled high. Sampling `enable` low stops the encoder at that edge, and the next start begins with a fresh preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the encoder while high |
| prog_mode | input | 1 | Choose the reset filler body instead of idle |
| pre_len | input | PRE_W | Preamble 1-bit count N |
| pkt_valid | input | 1 | Host offers a packet |
| pkt_ready | output | 1 | Packet buffer is free |
| pkt_data | input | 8*MAX_BYTES | Packet bytes; byte k in bits [8k+7:8k] |
| pkt_count | input | CNT_W | Number of bytes, 1 to MAX_BYTES |
| track_p | output | 1 | Track signal |
| track_n | output | 1 | Complement of the track signal while running |

## Verification
Each fault in this block becomes visible at the ports within one bit period. A wrong half-period counter changes the length of the next high pulse. A wrong bit index or a wrong shift register value turns one half-period from short to long or the reverse, at the exact cycle that bit starts. A stuck buffer flag shows up on `pkt_ready` in the cycle after the boundary, and it also changes which body follows that boundary. The reference model predicts both rails and `pkt_ready` every cycle. Any such fault therefore produces a mismatch no later than the end of the first affected bit.

// File: rtl/dcc_enc_pkg.sv
package dcc_enc_pkg;

    localparam int FRAME_W  = 64;
    localparam int IDLE_LEN = 28;
    // idle body, first bit in the MSB: 8 ones, 10 zeros, 8 ones, one, zero
    localparam logic [IDLE_LEN-1:0] IDLE_SEQ = 28'hFF003FE;

    typedef enum logic {
        PH_PRE  = 1'b0,
        PH_BODY = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_HOST  = 2'd1,
        SRC_RESET = 2'd2
    } src_e;

endpackage

// File: rtl/dcc_bit_timer.sv
module dcc_bit_timer #(
    parameter int ONE_HALF  = 4640,
    parameter int ZERO_HALF = 8000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic load_i,
    input  logic bit_i,
    output logic active_o,
    output logic level_o,
    output logic end_o
);
    localparam int MAXH = (ONE_HALF > ZERO_HALF) ? ONE_HALF : ZERO_HALF;
    localparam int CW   = $clog2(2 * MAXH);

    typedef struct packed {
        logic          active;
        logic          value;
        logic [CW-1:0] cnt;
    } tstate_t;

    tstate_t s_d, s_q;
    logic [CW-1:0] half_len;
    logic [CW-1:0] last_cnt;

    always_comb begin
        half_len = s_q.value ? CW'(ONE_HALF) : CW'(ZERO_HALF);
        last_cnt = s_q.value ? CW'(2 * ONE_HALF - 1) : CW'(2 * ZERO_HALF - 1);
        level_o  = s_q.active && (s_q.cnt < half_len);
        end_o    = s_q.active && (s_q.cnt == last_cnt);
        active_o = s_q.active;

        s_d = s_q;
        if (clear_i) begin
            s_d.active = 1'b0;
            s_d.cnt    = '0;
        end else if (load_i) begin
            s_d.active = 1'b1;
            s_d.value  = bit_i;
            s_d.cnt    = '0;
        end else if (s_q.active) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R1: a freshly loaded bit opens with its high half
    p_load_high_r1: assert property (@(posedge clk) disable iff (rst)
        (load_i && !clear_i) |=> level_o);

    // R2: the last cycle of any bit lies in its low half
    p_bit_ends_low_r2: assert property (@(posedge clk) disable iff (rst)
        end_o |-> !level_o);

endmodule

// File: rtl/dcc_packet_framer.sv
module dcc_packet_framer
    import dcc_enc_pkg::*;
#(
    parameter int MAX_BYTES = 5,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1),
    parameter int LEN_W     = $clog2(FRAME_W + 1)
) (
    input  src_e                   sel_i,
    input  logic [8*MAX_BYTES-1:0] data_i,
    input  logic [CNT_W-1:0]       count_i,
    output logic [FRAME_W-1:0]     frame_o,
    output logic [LEN_W-1:0]       len_o
);
    logic [8*MAX_BYTES-1:0] bytes_v;
    int                     n_v;

    always_comb begin
        frame_o = '0;
        len_o   = '0;
        bytes_v = (sel_i == SRC_HOST) ? data_i : '0;
        n_v     = (sel_i == SRC_HOST) ? int'(count_i) : 2;
        if (sel_i == SRC_IDLE) begin
            frame_o = {IDLE_SEQ, {(FRAME_W - IDLE_LEN){1'b0}}};
            len_o   = LEN_W'(IDLE_LEN);
        end else begin
            for (int k = 0; k < MAX_BYTES; k++) begin
                if (k < n_v) begin
                    for (int j = 0; j < 8; j++) begin
                        frame_o[FRAME_W - 1 - 9*k - (7 - j)] = bytes_v[8*k + j];
                    end
                    frame_o[FRAME_W - 9 - 9*k] = (k == n_v - 1);
                end
            end
            len_o = LEN_W'(9 * n_v);
        end
    end

endmodule

// File: rtl/dcc_track_encoder.sv
module dcc_track_encoder
    import dcc_enc_pkg::*;
#(
    parameter int ONE_HALF  = 4640,
    parameter int ZERO_HALF = 8000,
    parameter int PRE_W     = 5,
    parameter int MAX_BYTES = 5,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   prog_mode,
    input  logic [PRE_W-1:0]       pre_len,
    input  logic                   pkt_valid,
    output logic                   pkt_ready,
    input  logic [8*MAX_BYTES-1:0] pkt_data,
    input  logic [CNT_W-1:0]       pkt_count,
    output logic                   track_p,
    output logic                   track_n
);
    localparam int LEN_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        phase_e                 phase;
        logic [PRE_W-1:0]       pre_idx;
        logic [PRE_W-1:0]       pre_n;
        logic [FRAME_W-1:0]     sr;
        logic [LEN_W-1:0]       left;
        logic                   full;
        logic [8*MAX_BYTES-1:0] data;
        logic [CNT_W-1:0]       count;
    } enc_state_t;

    enc_state_t s_d, s_q;

    logic               t_load, t_bit, t_active, t_level, t_end;
    logic               accept;
    src_e               src_sel;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   frame_len;

    assign src_sel = s_q.full ? SRC_HOST : (prog_mode ? SRC_RESET : SRC_IDLE);

    dcc_packet_framer #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W),
        .LEN_W     (LEN_W)
    ) u_framer (
        .sel_i   (src_sel),
        .data_i  (s_q.data),
        .count_i (s_q.count),
        .frame_o (frame),
        .len_o   (frame_len)
    );

    dcc_bit_timer #(
        .ONE_HALF  (ONE_HALF),
        .ZERO_HALF (ZERO_HALF)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (!enable),
        .load_i   (t_load),
        .bit_i    (t_bit),
        .active_o (t_active),
        .level_o  (t_level),
        .end_o    (t_end)
    );

    always_comb begin
        s_d    = s_q;
        t_load = 1'b0;
        t_bit  = 1'b1;
        accept = pkt_valid && !s_q.full && (pkt_count != '0)
                 && (int'(pkt_count) <= MAX_BYTES);

        if (!enable) begin
            s_d.phase = PH_PRE;
        end else if (!t_active) begin
            s_d.phase   = PH_PRE;
            s_d.pre_idx = '0;
            s_d.pre_n   = pre_len;
            t_load      = 1'b1;
            t_bit       = (pre_len != '0);
        end else if (t_end) begin
            t_load = 1'b1;
            if (s_q.phase == PH_PRE) begin
                if (s_q.pre_idx == s_q.pre_n) begin
                    s_d.phase = PH_BODY;
                    t_bit     = frame[FRAME_W-1];
                    s_d.sr    = frame << 1;
                    s_d.left  = frame_len - 1'b1;
                    s_d.full  = 1'b0;
                end else begin
                    s_d.pre_idx = s_q.pre_idx + 1'b1;
                    t_bit       = (PRE_W'(s_q.pre_idx + 1'b1) != s_q.pre_n);
                end
            end else begin
                if (s_q.left == '0) begin
                    s_d.phase   = PH_PRE;
                    s_d.pre_idx = '0;
                    s_d.pre_n   = pre_len;
                    t_bit       = (pre_len != '0);
                end else begin
                    t_bit    = s_q.sr[FRAME_W-1];
                    s_d.sr   = s_q.sr << 1;
                    s_d.left = s_q.left - 1'b1;
                end
            end
        end

        if (accept) begin
            s_d.full  = 1'b1;
            s_d.data  = pkt_data;
            s_d.count = pkt_count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign pkt_ready = !s_q.full;
    assign track_p   = t_level;
    assign track_n   = t_active && !t_level;

    // R10: dropping enable silences both rails at the next edge
    p_stop_low_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!track_p && !track_n));

    // R10: a start puts the first preamble half high right away
    p_start_high_r10: assert property (@(posedge clk) disable iff (rst)
        (enable && !t_active) |=> track_p);

    // R7: an accepted beat occupies the buffer
    p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
        accept |=> !pkt_ready);

    // R8: a boundary that takes the buffer frees it
    p_take_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (enable && t_end && s_q.phase == PH_PRE && s_q.pre_idx == s_q.pre_n && s_q.full)
        |=> (pkt_ready && s_q.phase == PH_BODY));

    // R4: the preamble index never runs past the sampled length
    p_pre_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_PRE) |-> (s_q.pre_idx <= s_q.pre_n));

endmodule

// File: tb/sim_dcc_track_encoder.sv
module sim_dcc_track_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int ONE_H      = 3;
    localparam int ZERO_H     = 5;
    localparam int PRE_W      = 5;
    localparam int MAXB       = 5;
    localparam int CNT_W      = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic             prog_mode = 1'b0;
    logic [PRE_W-1:0] pre_len = 5'd4;
    logic             pkt_valid = 1'b0;
    logic             pkt_ready;
    logic [8*MAXB-1:0] pkt_data = '0;
    logic [CNT_W-1:0] pkt_count = '0;
    logic             track_p, track_n;

    int errors = 0;
    int checks = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcc_track_encoder #(
        .ONE_HALF  (ONE_H),
        .ZERO_HALF (ZERO_H),
        .PRE_W     (PRE_W),
        .MAX_BYTES (MAXB),
        .CNT_W     (CNT_W)
    ) u0 (
        .clk (clk), .rst (rst), .enable (enable), .prog_mode (prog_mode),
        .pre_len (pre_len), .pkt_valid (pkt_valid), .pkt_ready (pkt_ready),
        .pkt_data (pkt_data), .pkt_count (pkt_count),
        .track_p (track_p), .track_n (track_n)
    );

    // ---------------- reference model ----------------
    int        q[$];
    string     kind = "R10";
    bit        m_act = 1'b0;
    bit        m_inpre = 1'b0;
    bit        m_full = 1'b0;
    bit        took;
    int        m_bit = 1;
    int        m_cnt = 0;
    logic [8*MAXB-1:0] m_data = '0;
    int        m_n = 0;
    int        obs_high = 0;

    function automatic int half(int b);
        return b ? ONE_H : ZERO_H;
    endfunction

    task automatic push_pre();
        m_inpre = 1'b1;
        kind = "R4";
        for (int i = 0; i < int'(pre_len); i++) q.push_back(1);
        q.push_back(0);
    endtask

    task automatic push_frame(logic [8*MAXB-1:0] d, int n);
        for (int k = 0; k < n; k++) begin
            for (int j = 7; j >= 0; j--) q.push_back(int'(d[8*k + j]));
            q.push_back((k == n - 1) ? 1 : 0);
        end
    endtask

    task automatic push_body();
        m_inpre = 1'b0;
        if (m_full) begin
            kind = "R6 R8";
            push_frame(m_data, m_n);
            took = 1'b1;
        end else if (prog_mode) begin
            kind = "R9";
            push_frame('0, 2);
        end else begin
            kind = "R5";
            for (int i = 0; i < 8; i++) q.push_back(1);
            for (int i = 0; i < 10; i++) q.push_back(0);
            for (int i = 0; i < 9; i++) q.push_back(1);
            q.push_back(0);
        end
    endtask

    task automatic next_bit();
        m_bit = q.pop_front();
        m_cnt = 0;
        m_act = 1'b1;
    endtask

    always @(posedge clk) begin
        bit acc;
        if (rst) begin
            m_act = 1'b0;
            m_full = 1'b0;
            q.delete();
        end else begin
            took = 1'b0;
            acc = pkt_valid && !m_full && (pkt_count >= 1) && (pkt_count <= MAXB);
            if (!enable) begin
                m_act = 1'b0;
                q.delete();
            end else if (!m_act) begin
                push_pre();
                next_bit();
            end else begin
                m_cnt++;
                if (m_cnt == 2 * half(m_bit)) begin
                    if (q.size() == 0) begin
                        if (m_inpre) push_body();
                        else         push_pre();
                    end
                    next_bit();
                end
            end
            if (took) m_full = 1'b0;
            if (acc) begin
                m_full = 1'b1;
                m_data = pkt_data;
                m_n = int'(pkt_count);
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic exp_p;
        if (chk_on && !finished) begin
            exp_p = m_act && (m_cnt < half(m_bit));
            chk(kind, track_p, exp_p);
            chk("R3", track_n, m_act && !exp_p);
            chk("R7", pkt_ready, !m_full);
            if (m_act) begin
                if (m_cnt == 0) obs_high = 0;
                if (track_p === 1'b1) obs_high++;
                if (m_cnt == 2 * half(m_bit) - 1) begin
                    checks++;
                    if (obs_high != half(m_bit)) begin
                        errors++;
                        $display("FAIL %s: high cycles %0d expected %0d",
                                 m_bit ? "R1" : "R2", obs_high, half(m_bit));
                    end
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(logic [8*MAXB-1:0] d, int n);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_data  = d;
        pkt_count = CNT_W'(n);
        while (!pkt_ready) @(negedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic offer_bad(int n);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_data  = 40'hDEADBEEF55;
        pkt_count = CNT_W'(n);
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        chk_on = 1'b1;
        // R10: reset state
        chk("R10", track_p, 1'b0);
        chk("R10", track_n, 1'b0);
        chk("R10", pkt_ready, 1'b1);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        enable = 1'b1;                      // R10 start, R5 idle bodies
        repeat (800) @(negedge clk);
        send(40'h00_00_81_3C_A5, 3);        // R6 three bytes
        repeat (600) @(negedge clk);
        pre_len = 5'd10;                    // R4 new length
        send(40'h11_F0_0F_C3_7E, 5);        // R6 five bytes
        send(40'h00_00_00_00_99, 1);        // R7 waits while buffer full
        repeat (900) @(negedge clk);
        offer_bad(0);                       // R7 dropped
        offer_bad(7);                       // R7 dropped
        repeat (500) @(negedge clk);
        prog_mode = 1'b1;                   // R9 reset bodies
        repeat (700) @(negedge clk);
        prog_mode = 1'b0;
        pre_len = 5'd0;                     // R4 lone zero preamble
        send(40'h00_00_00_55_AA, 2);
        repeat (600) @(negedge clk);
        enable = 1'b0;                      // R10 stop mid-stream
        repeat (30) @(negedge clk);
        chk("R10", track_p, 1'b0);
        pre_len = 5'd3;
        enable = 1'b1;
        repeat (300) @(negedge clk);
        rst = 1'b1;                         // R10 reset mid-stream
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (400) @(negedge clk);
        finish_run();
    end

endmodule